// File: doc/BRIEF.md
# Receive Word Slot Mask with Receive FIFO

This block sits in the receive path of a serial audio port. It lies between the deserialiser, which presents one complete word per strobe, and software, which drains words through a register port. For every word in a frame it decides whether the word goes into the receive FIFO or is thrown away. The decision comes from a per-slot mask bit.

Software writes the mask into a holding register. A second, active copy gates the incoming words. The active copy takes the holding value only at two moments: when the receiver is switched on, and at every frame end. As a result, the set of dropped slots can change from frame to frame and never changes inside a frame.

The block counts slots itself. The count restarts at each frame end and advances with each word strobe. An eight-entry FIFO holds the accepted words. Software reads them through the register port, and a sticky flag records words lost to a full FIFO.

Top module: `rx_slot_mask`

## Requirements
- R1: After reset the holding mask and the active mask are both zero, so every slot is enabled. The FIFO is empty and the overflow flag reads 0.
- R2: Register word address 1 holds the mask. Bits [1:0] store mask bits for slots 0 and 1. Bits [31:2] always read 0, and writes to them have no effect.
- R3: The slot counter is 0 after reset and advances by one on every word strobe, whether or not the word is accepted. A frame end sets it back to 0, and a word arriving in the same cycle as a frame end still uses the old count. Slots 2 and above are never masked.
- R4: A word whose slot has its active mask bit at 1 is not written to the FIFO. A word whose slot has its active mask bit at 0 is written to the FIFO.
- R5: When the receiver enable changes from 0 to 1, the active mask loads the holding value.
- R6: At every frame end the active mask loads the holding value, so a write made mid-frame takes effect from the next frame. If a mask write and a frame end fall in the same cycle, the old holding value is loaded, and the new value takes effect at the following frame end.
- R7: A read of word address 0 while the channel enable is 1 and the FIFO is not empty returns the oldest word and removes it.
- R8: A read of word address 0 while the FIFO is empty, or while the channel enable is 0, returns 0 and removes nothing.
- R9: Words are written to the FIFO only while both the receiver enable and the channel enable are 1.
- R10: The FIFO holds 8 words of 32 bits. An unmasked word that arrives while the FIFO holds 8 words at the start of that cycle is dropped, and bit 0 of word address 2 (the overflow flag) is set. Writing 1 to that bit clears it, but a new overflow in the same cycle keeps it set. Word address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| ch_en | input | 1 | Receive channel enable |
| word_valid | input | 1 | One received word is present this cycle |
| word_data | input | 32 | Received word |
| frame_end | input | 1 | Last cycle of the current frame |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the read strobe |

## Verification
The mask is tried with every value in both slots, in frames of one to five words, so that masked slots, unmasked slots and slots beyond the mask width all occur. Mask writes are placed mid-frame, in the same cycle as a frame end, and just before a receiver enable edge. These placements separate loading on frame boundaries from loading on writes, and the old holding value from the new one. Random toggling of the two enables with bursts of words shows whether acceptance depends on both enables. Filling the FIFO past eight words, then reading it empty and reading once more, covers the overflow flag, its clearing, and the read of an empty FIFO.

// File: rtl/rx_slot_mask.sv
module rx_slot_mask #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int MASK_W = 2,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              ch_en,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              frame_end,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int MI_W  = $clog2(MASK_W);
  localparam logic [1:0] A_DATA = 2'd0, A_MASK = 2'd1, A_STAT = 2'd2;

  logic [MASK_W-1:0] hold_mask, act_mask;
  logic [SLOT_W-1:0] slot;
  logic              rx_en_q, ovf;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  wire empty    = (count == '0);
  wire full     = (count == CNT_W'(DEPTH));
  wire en_rise  = rx_en & ~rx_en_q;
  wire reload   = frame_end | en_rise;
  wire masked   = (slot < SLOT_W'(MASK_W)) && act_mask[slot[MI_W-1:0]];
  wire accept   = word_valid & rx_en & ch_en & ~masked;
  wire push     = accept & ~full;
  wire pop      = reg_rd & (reg_addr == A_DATA) & ch_en & ~empty;
  wire ovf_set  = accept & full;
  wire ovf_clr  = reg_wr & (reg_addr == A_STAT) & reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_mask <= '0;
      act_mask  <= '0;
      rx_en_q   <= 1'b0;
      slot      <= '0;
      ovf       <= 1'b0;
    end else begin
      rx_en_q <= rx_en;
      if (reg_wr && reg_addr == A_MASK) hold_mask <= reg_wdata[MASK_W-1:0];
      if (reload) act_mask <= hold_mask;
      if (frame_end) slot <= '0;
      else if (word_valid) slot <= slot + 1'b1;
      if (ovf_set) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= word_data;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd)
      case (reg_addr)
        A_DATA:  reg_rdata = (ch_en && !empty) ? mem[rd_ptr] : '0;
        A_MASK:  reg_rdata[MASK_W-1:0] = hold_mask;
        A_STAT:  reg_rdata[0] = ovf;
        default: reg_rdata = '0;
      endcase
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  a_r5_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> act_mask == $past(hold_mask));
  a_r6_frame_loads: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> act_mask == $past(hold_mask));
  a_r6_stable_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(act_mask));
  a_r4_masked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && masked && !pop) |=> count == $past(count));
  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_DATA && empty) |-> reg_rdata == '0);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_MASK) |-> reg_rdata[DATA_W-1:MASK_W] == '0);
  a_r3_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> slot == '0);
endmodule

// File: tb/rx_slot_mask_test.sv
module rx_slot_mask_test;
  logic        clk = 0, rst_n = 0;
  logic        rx_en = 0, ch_en = 0, word_valid = 0, frame_end = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] word_data = 0, reg_wdata = 0, reg_rdata;

  int checks = 0, errors = 0;
  logic [31:0] q[$];
  logic [1:0]  m_hold = 0, m_act = 0;
  int          m_slot = 0;
  logic        m_ovf = 0, m_enq = 0;

  rx_slot_mask uut (.*);

  always #2.5 clk = ~clk;

  initial begin
    int n = 0;
    while (n < 150000) begin @(posedge clk); n++; end
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] exp_rdata();
    if (!reg_rd) return 0;
    case (reg_addr)
      2'd0: return (ch_en && q.size() > 0) ? q[0] : 32'd0;
      2'd1: return {30'd0, m_hold};
      2'd2: return {31'd0, m_ovf};
      default: return 0;
    endcase
  endfunction

  function automatic string req_of();
    case (reg_addr)
      2'd0: return (q.size() > 0 && ch_en) ? "R7/R4/R9" : "R8";
      2'd1: return "R2";
      2'd2: return "R10";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step();
    logic msk, acc, full, pop, fire;
    logic [1:0] old_hold = m_hold;
    msk  = (m_slot < 2) && m_act[m_slot];
    acc  = word_valid && rx_en && ch_en && !msk;
    full = (q.size() == 8);
    pop  = reg_rd && reg_addr == 0 && ch_en && q.size() > 0;
    fire = rx_en && !m_enq;
    if (pop) void'(q.pop_front());
    if (acc && !full) q.push_back(word_data);
    if (reg_wr && reg_addr == 1) m_hold = reg_wdata[1:0];
    if (acc && full) m_ovf = 1;
    else if (reg_wr && reg_addr == 2 && reg_wdata[0]) m_ovf = 0;
    if (frame_end || fire) m_act = old_hold;
    if (frame_end) m_slot = 0;
    else if (word_valid) m_slot = (m_slot + 1) % 16;
    m_enq = rx_en;
  endtask

  task automatic step(string tag = "");
    logic [31:0] e;
    #1;
    if (reg_rd) begin
      e = exp_rdata();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s %s addr=%0d actual=%h expected=%h", req_of(), tag, reg_addr, reg_rdata, e);
      end
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    {word_valid, frame_end, reg_wr, reg_rd} = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic fe = 0);
    reg_wr = 1; reg_addr = a; reg_wdata = d; frame_end = fe; step();
  endtask
  task automatic rd(input logic [1:0] a, string tag);
    reg_rd = 1; reg_addr = a; step(tag);
  endtask
  task automatic word(input logic [31:0] d, input logic fe = 0);
    word_valid = 1; word_data = d; frame_end = fe; step();
  endtask
  task automatic drain(string tag);
    while (q.size() > 0) rd(0, tag);
    rd(0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(1, "R1 reset mask"); rd(2, "R1 reset ovf"); ch_en = 1; rd(0, "R1 reset empty");
    // R2: reserved bits
    wr(1, 32'hFFFF_FFFE); rd(1, "R2 reserved");
    // R5: enable edge loads mask 2'b10 -> slot1 masked
    rx_en = 1; step();
    word(32'hA0); word(32'hA1); word(32'hA2); word(32'hA3, 1);
    drain("R5 R3 slot mask");
    // R6: mid-frame write, then write coinciding with frame end
    word(32'hB0); wr(1, 32'h1); word(32'hB1); word(32'hB2, 1);
    word(32'hB3); word(32'hB4);
    wr(1, 32'h3, 1);
    word(32'hC0); word(32'hC1, 1);
    word(32'hC2); word(32'hC3); word(32'hC4, 1);
    drain("R6 reload timing");
    // R9: channel or receiver disabled
    wr(1, 0, 1);
    ch_en = 0; word(32'hD0); rd(0, "R8 ch off read"); ch_en = 1;
    rx_en = 0; word(32'hD1, 1); rx_en = 1; step();
    word(32'hD2); drain("R9 enables");
    // R10: overflow
    for (int i = 0; i < 10; i++) word(32'hE0 + i);
    rd(2, "R10 ovf set"); wr(2, 0); rd(2, "R10 ovf hold");
    wr(2, 1); rd(2, "R10 ovf clear"); drain("R10 fifo order");
    rd(3, "R10 unused addr");
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      word_valid = (r < 45); word_data = $urandom;
      frame_end = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 199) == 0) rx_en = ~rx_en;
      if ($urandom_range(0, 99) == 0) ch_en = ~ch_en;
      r = $urandom_range(0, 99);
      if (r < 30) begin reg_rd = 1; reg_addr = (r < 22) ? 2'd0 : 2'($urandom_range(1, 3)); end
      else if (r < 36) begin reg_wr = 1; reg_addr = 2'($urandom_range(1, 2)); reg_wdata = $urandom; end
      step("rand");
    end
    ch_en = 1; drain("R7 final drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h5EED));
endmodule